// File: doc/BRIEF.md
# Split-Word SHA-512 Mixing Unit

This unit is an execute-stage helper for a 32-bit processor. SHA-512 works on 64-bit words, but a 32-bit machine holds each such word as two 32-bit halves in separate registers. The unit takes two 32-bit operands, `word_a` and `word_b`, and returns one 32-bit half of a SHA-512 big-Sigma or small-sigma function. It uses only zero-filling 32-bit shifts and XOR, with no 64-bit rotator.

For the two big-Sigma functions a single operation serves both halves. It is issued once as (high, low) and once as (low, high). The two small-sigma functions contain a plain right shift, so they are not symmetric. Each therefore has one high-half operation and one low-half operation. The low-half operation is issued with the operands swapped, (low, high).

The operation comes from a 5-bit function code and a 2-bit byte-select field. A request is a one-cycle `in_valid` pulse. The result and its flags appear in registers on the following cycle. Codes outside the supported set raise an illegal flag and return zero.

Top module: `sxm_unit`

## Requirements
- R1: Function code 0x08 (byte select 1) returns (A<<25)^(A<<30)^(A>>28)^(B>>7)^(B>>2)^(B<<4), where A is `word_a`, B is `word_b`, and every shift is a 32-bit logical shift with zero fill.
- R2: Function code 0x09 (byte select 1) returns (A<<23)^(A>>14)^(A>>18)^(B>>9)^(B<<18)^(B<<14).
- R3: Function code 0x0a (byte select 1) returns (A>>1)^(A>>7)^(A>>8)^(B<<31)^(B<<25)^(B<<24). This is the low-half small-sigma-0 operation.
- R4: Function code 0x0b (byte select 1) returns (A<<3)^(A>>6)^(A>>19)^(B>>29)^(B<<26)^(B<<13). This is the low-half small-sigma-1 operation.
- R5: Function code 0x0e (byte select 1) returns (A>>1)^(A>>7)^(A>>8)^(B<<31)^(B<<24). It has no B<<25 term.
- R6: Function code 0x0f (byte select 1) returns (A<<3)^(A>>6)^(A>>19)^(B>>29)^(B<<13). It has no B<<26 term.
- R7: A byte select other than 1 (0, 2 or 3) with any function code sets `illegal` and gives a result of zero.
- R8: A function code outside {0x08, 0x09, 0x0a, 0x0b, 0x0e, 0x0f} sets `illegal` and gives a result of zero.
- R9: `out_valid` is high in exactly the cycle after each cycle in which `in_valid` is high, and low otherwise. Back-to-back requests produce back-to-back results.
- R10: While `in_valid` is low, `result` and `illegal` keep their last values, whatever the other inputs do.
- R11: A synchronous active-high `rst` clears `result`, `out_valid` and `illegal`.
- R12: For any 64-bit word X = {H, L}, two requests give the SHA-512 function of X as {high-half result, low-half result}. The high half comes from (H, L) and the low half from (L, H). Big-Sigma-0 uses 0x08 for both halves. Big-Sigma-1 uses 0x09 for both halves. Small-sigma-0 uses 0x0e for the high half and 0x0a for the low half. Small-sigma-1 uses 0x0f for the high half and 0x0b for the low half.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe, one cycle per operation |
| func_code | input | 5 | Operation code |
| byte_sel | input | 2 | Byte-select field; must be 1 |
| word_a | input | 32 | First operand half |
| word_b | input | 32 | Second operand half |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| result | output | 32 | Registered 32-bit result half |
| illegal | output | 1 | Registered unsupported-operation flag |

## Verification
The bench composes full 64-bit values from pairs of requests and compares them with rotate-based SHA-512 definitions. This catches a missing or extra low-half term (B<<25, B<<26), a wrong shift direction, and an operand-order mistake, each of which corrupts bits near the half boundary. Single-bit and all-ones words are included so that a term leaking across the boundary shows up as an isolated wrong bit. The unused codes 0x0c and 0x0d sit between valid codes, and every wrong byte select is tried: a loose decoder would return a real result instead of zero with the flag set. Idle cycles with changing inputs expose a result register that is not gated by `in_valid`. Back-to-back requests expose a strobe that stretches or drops.

// File: rtl/sxm_pkg.sv
package sxm_pkg;
  localparam int FUNC_W   = 5;
  localparam int BSEL_W   = 2;
  localparam logic [BSEL_W-1:0] BSEL_REQ = 2'd1;

  localparam logic [FUNC_W-1:0] FC_BSUM0    = 5'h08;
  localparam logic [FUNC_W-1:0] FC_BSUM1    = 5'h09;
  localparam logic [FUNC_W-1:0] FC_SSIG0_LO = 5'h0a;
  localparam logic [FUNC_W-1:0] FC_SSIG1_LO = 5'h0b;
  localparam logic [FUNC_W-1:0] FC_SSIG0_HI = 5'h0e;
  localparam logic [FUNC_W-1:0] FC_SSIG1_HI = 5'h0f;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_BSUM0,
    OP_BSUM1,
    OP_SSIG0_LO,
    OP_SSIG1_LO,
    OP_SSIG0_HI,
    OP_SSIG1_HI
  } op_e;
endpackage

// File: rtl/sxm_decode.sv
module sxm_decode
  import sxm_pkg::*;
(
  input  logic [FUNC_W-1:0] func_code,
  input  logic [BSEL_W-1:0] byte_sel,
  output op_e               op,
  output logic              bad
);
  always_comb begin
    op = OP_NONE;
    if (byte_sel == BSEL_REQ) begin
      case (func_code)
        FC_BSUM0:    op = OP_BSUM0;
        FC_BSUM1:    op = OP_BSUM1;
        FC_SSIG0_LO: op = OP_SSIG0_LO;
        FC_SSIG1_LO: op = OP_SSIG1_LO;
        FC_SSIG0_HI: op = OP_SSIG0_HI;
        FC_SSIG1_HI: op = OP_SSIG1_HI;
        default:     op = OP_NONE;
      endcase
    end
    bad = (op == OP_NONE);
  end
endmodule

// File: rtl/sxm_mix.sv
module sxm_mix
  import sxm_pkg::*;
#(
  parameter int W = 32
) (
  input  op_e          op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  // Terms shared by the high/low forms of each small-sigma function
  logic [W-1:0] s0_core, s1_core;

  always_comb begin
    s0_core = (a >> 1) ^ (a >> 7) ^ (a >> 8) ^ (b << 31) ^ (b << 24);
    s1_core = (a << 3) ^ (a >> 6) ^ (a >> 19) ^ (b >> 29) ^ (b << 13);
    case (op)
      OP_BSUM0:    y = (a << 25) ^ (a << 30) ^ (a >> 28) ^
                       (b >> 7) ^ (b >> 2) ^ (b << 4);
      OP_BSUM1:    y = (a << 23) ^ (a >> 14) ^ (a >> 18) ^
                       (b >> 9) ^ (b << 18) ^ (b << 14);
      OP_SSIG0_HI: y = s0_core;
      OP_SSIG0_LO: y = s0_core ^ (b << 25);
      OP_SSIG1_HI: y = s1_core;
      OP_SSIG1_LO: y = s1_core ^ (b << 26);
      default:     y = '0;
    endcase
  end
endmodule

// File: rtl/sxm_unit.sv
module sxm_unit
  import sxm_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [FUNC_W-1:0] func_code,
  input  logic [BSEL_W-1:0] byte_sel,
  input  logic [WORD_W-1:0] word_a,
  input  logic [WORD_W-1:0] word_b,
  output logic              out_valid,
  output logic [WORD_W-1:0] result,
  output logic              illegal
);
  op_e               op;
  logic              bad;
  logic [WORD_W-1:0] mixed;

  sxm_decode u_dec (
    .func_code (func_code),
    .byte_sel  (byte_sel),
    .op        (op),
    .bad       (bad)
  );

  sxm_mix #(.W(WORD_W)) u_mix (
    .op (op),
    .a  (word_a),
    .b  (word_b),
    .y  (mixed)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= bad ? '0 : mixed;
        illegal <= bad;
      end
    end
  end
endmodule

// File: rtl/sxm_unit_chk.sv
module sxm_unit_chk
  import sxm_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [BSEL_W-1:0] byte_sel,
  input logic              out_valid,
  input logic [WORD_W-1:0] result,
  input logic              illegal
);
  AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R9
  AST_NO_STRAY_STROBE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R9
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(result) && $stable(illegal))); // R10
  AST_BAD_SEL_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && byte_sel != BSEL_REQ) |=> (illegal && result == '0)); // R7
  AST_FLAG_ZEROES: assert property (@(posedge clk) disable iff (rst)
    (out_valid && illegal) |-> (result == '0)); // R8
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!out_valid && !illegal && result == '0)); // R11
endmodule

bind sxm_unit sxm_unit_chk #(.WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .byte_sel  (byte_sel),
  .out_valid (out_valid),
  .result    (result),
  .illegal   (illegal)
);

// File: tb/sxm_unit_test.sv
module sxm_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [4:0]  func_code = '0;
  logic [1:0]  byte_sel = '0;
  logic [31:0] word_a = '0;
  logic [31:0] word_b = '0;
  logic        out_valid;
  logic [31:0] result;
  logic        illegal;

  int errors = 0;
  int checks = 0;

  sxm_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .func_code(func_code),
    .byte_sel(byte_sel), .word_a(word_a), .word_b(word_b),
    .out_valid(out_valid), .result(result), .illegal(illegal)
  );

  always #10 clk = ~clk; // 50 MHz

  function automatic logic [63:0] ror64(logic [63:0] x, int n);
    return (x >> n) | (x << (64 - n));
  endfunction
  function automatic logic [63:0] ref_bsum0(logic [63:0] x);
    return ror64(x, 28) ^ ror64(x, 34) ^ ror64(x, 39);
  endfunction
  function automatic logic [63:0] ref_bsum1(logic [63:0] x);
    return ror64(x, 14) ^ ror64(x, 18) ^ ror64(x, 41);
  endfunction
  function automatic logic [63:0] ref_ssig0(logic [63:0] x);
    return ror64(x, 1) ^ ror64(x, 8) ^ (x >> 7);
  endfunction
  function automatic logic [63:0] ref_ssig1(logic [63:0] x);
    return ror64(x, 19) ^ ror64(x, 61) ^ (x >> 6);
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One request; samples the registered outputs at the next falling edge
  task automatic issue(input logic [4:0] fc, input logic [1:0] bs,
                       input logic [31:0] a, input logic [31:0] b,
                       output logic [31:0] r, output logic ill, output logic ov);
    @(negedge clk);
    func_code = fc; byte_sel = bs; word_a = a; word_b = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    r = result; ill = illegal; ov = out_valid;
  endtask

  task automatic t_reset();
    check("R11 out_valid after reset", {63'd0, out_valid}, 64'd0);
    check("R11 illegal after reset", {63'd0, illegal}, 64'd0);
    check("R11 result after reset", {32'd0, result}, 64'd0);
  endtask

  task automatic t_pair(string tag, logic [4:0] fc_hi, logic [4:0] fc_lo,
                        logic [63:0] x, logic [63:0] exp);
    logic [31:0] rh, rl;
    logic ih, il, vh, vl;
    issue(fc_hi, 2'd1, x[63:32], x[31:0], rh, ih, vh);
    issue(fc_lo, 2'd1, x[31:0], x[63:32], rl, il, vl);
    check({tag, " R12 composed"}, {rh, rl}, exp);
    check({tag, " R9 strobes / flag"}, {61'd0, vh, vl, ih | il}, {61'd0, 3'b110});
  endtask

  task automatic t_all_functions(logic [63:0] x);
    t_pair("R1 big0", 5'h08, 5'h08, x, ref_bsum0(x));
    t_pair("R2 big1", 5'h09, 5'h09, x, ref_bsum1(x));
    t_pair("R5 R3 small0", 5'h0e, 5'h0a, x, ref_ssig0(x));
    t_pair("R6 R4 small1", 5'h0f, 5'h0b, x, ref_ssig1(x));
  endtask

  // Low/high forms differ by one term: B<<25 for small0, B<<26 for small1
  task automatic t_extra_term();
    logic [31:0] r; logic i, v;
    issue(5'h0a, 2'd1, 32'd0, 32'd1, r, i, v);
    check("R3 isolated B terms", {32'd0, r}, {32'd0, 32'h8300_0000});
    issue(5'h0e, 2'd1, 32'd0, 32'd1, r, i, v);
    check("R5 isolated B terms", {32'd0, r}, {32'd0, 32'h8100_0000});
    issue(5'h0b, 2'd1, 32'd0, 32'd1, r, i, v);
    check("R4 isolated B terms", {32'd0, r}, {32'd0, 32'h0400_2000});
    issue(5'h0f, 2'd1, 32'd0, 32'd1, r, i, v);
    check("R6 isolated B terms", {32'd0, r}, {32'd0, 32'h0000_2000});
  endtask

  task automatic t_bad_select();
    logic [31:0] r; logic i, v;
    for (int bs = 0; bs < 4; bs++) begin
      if (bs == 1) continue;
      issue(5'h08, 2'(bs), 32'hFFFF_FFFF, 32'h1234_5678, r, i, v);
      check("R7 bad byte select", {30'd0, v, i, r}, {30'd0, 1'b1, 1'b1, 32'd0});
    end
  endtask

  task automatic t_bad_code();
    logic [31:0] r; logic i, v;
    logic [4:0] codes [4] = '{5'h0c, 5'h0d, 5'h00, 5'h1f};
    foreach (codes[k]) begin
      issue(codes[k], 2'd1, 32'hDEAD_BEEF, 32'hFFFF_FFFF, r, i, v);
      check("R8 unlisted code", {30'd0, v, i, r}, {30'd0, 1'b1, 1'b1, 32'd0});
    end
    issue(5'h09, 2'd1, 32'd1, 32'd0, r, i, v);
    check("R8 flag clears on legal", {31'd0, i, r}, {31'd0, 1'b0, 32'h0080_0000});
  endtask

  task automatic t_idle_hold();
    logic [31:0] r; logic i, v;
    issue(5'h08, 2'd1, 32'h0000_0001, 32'h0, r, i, v);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      func_code = 5'h1f; byte_sel = 2'd0;
      word_a = 32'hFFFF_0000 + c; word_b = 32'hAAAA_5555;
      check("R10 idle hold", {30'd0, out_valid, illegal, result},
            {30'd0, 1'b0, 1'b0, 32'h4200_0000});
    end
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    func_code = 5'h09; byte_sel = 2'd1; word_a = 32'h1; word_b = 32'h0; in_valid = 1'b1;
    @(negedge clk);
    check("R9 first of pair", {31'd0, out_valid, result}, {31'd0, 1'b1, 32'h0080_0000});
    func_code = 5'h0c;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 second of pair", {30'd0, out_valid, illegal, result}, {30'd0, 1'b1, 1'b1, 32'd0});
    @(negedge clk);
    check("R9 strobe drops", {63'd0, out_valid}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_all_functions(64'h0000_0000_0000_0001);
    t_all_functions(64'h8000_0000_0000_0000);
    t_all_functions(64'h0000_0001_8000_0000);
    t_all_functions(64'hFFFF_FFFF_FFFF_FFFF);
    for (int n = 0; n < 20; n++) t_all_functions({$urandom, $urandom});
    t_extra_term();
    t_bad_select();
    t_bad_code();
    t_idle_hold();
    t_back_to_back();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule